// File: doc/BRIEF.md
# Interrupt Stack Frame Sequencer

This block runs the stacking and unstacking steps of interrupt entry and return for a CPU whose code space is split into 64 KB segments. A 6-bit code segment register (CSR) and a 16-bit program counter together form a 22-bit fetch address, which covers 4 MB. A separate interrupt segment value names the segment that holds the handlers. A configuration bit picks one of two frame formats. In the short format the saved frame is the program counter and flags only, and the interrupt segment stands in for the CSR as the fetch segment for the whole handler. In the long format the old CSR is saved as well, and the CSR is then loaded from the interrupt segment, so the handler can jump anywhere in the 4 MB space.

Each stacked item is one byte. The block drives a byte-wide, descending push/pop stack port, one transfer per cycle. It reports the segment that instruction fetch must use. On return it hands back the restored program counter and flags. The frame format is latched when the interrupt is accepted, so a change of the configuration bit inside a handler cannot unbalance the stack.

Top module: `intr_frame_seq`

## Requirements
- R1: After reset the mode bit reads 0, which selects the short format. The block is idle with busy and done low, and both the CSR and the fetch segment read 0.
- R2: In short format, an accepted interrupt makes three pushes in consecutive cycles, beginning the cycle after the request: PC bits 7:0 first, then PC bits 15:8, then flags. Busy is high during the pushes, and done pulses for one cycle on the cycle after the last push.
- R3: While inside a short-format handler, the fetch segment follows the interrupt segment input. A CSR write still changes the CSR output but does not change the fetch segment.
- R4: In long format, entry pushes PC low byte, PC high byte, flags, and then the old CSR zero-extended to 8 bits. The CSR is then loaded from the interrupt segment, and done pulses the cycle after the fourth push. From then on the fetch segment is the CSR, including values later written by the handler.
- R5: A short-format return pops flags, then PC high byte, then PC low byte, in consecutive cycles. Pop data is taken from the stack port in the same cycle as the pop strobe. The CSR is not restored, and the fetch segment falls back to the CSR. Done pulses the cycle after the last pop, with the restored PC and flags on their outputs.
- R6: A long-format return pops the CSR byte first (its low 6 bits reload the CSR), then flags, PC high byte and PC low byte, with done the cycle after the fourth pop.
- R7: The return format is the format latched at entry, whatever the mode bit holds when the return is requested.
- R8: An interrupt request is ignored while a handler is active or a sequence is running. A return request is ignored when no handler is active.
- R9: A CSR write takes effect on the next cycle when the block is idle and is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we_i | input | 1 | Write strobe for the frame format bit |
| mode_wd_i | input | 1 | Format bit value: 0 short, 1 long |
| irq_take_i | input | 1 | Interrupt accepted, start entry |
| iret_i | input | 1 | Return from interrupt requested |
| pc_i | input | 16 | Program counter to save on entry |
| flags_i | input | 8 | Flags to save on entry |
| isr_i | input | 6 | Interrupt segment value |
| csr_we_i | input | 1 | CSR write strobe (inter-segment jump or call) |
| csr_wd_i | input | 6 | CSR write value |
| stk_push_o | output | 1 | Push one byte to the stack |
| stk_pop_o | output | 1 | Pop one byte from the stack |
| stk_wdata_o | output | 8 | Byte to push |
| stk_rdata_i | input | 8 | Top-of-stack byte, valid while popping |
| busy_o | output | 1 | A stacking or unstacking sequence is running |
| done_o | output | 1 | One-cycle pulse: sequence finished, fetch may start |
| ext_mode_o | output | 1 | Current frame format bit |
| csr_o | output | 6 | Code segment register |
| fetch_seg_o | output | 6 | Segment that instruction fetch uses |
| ret_pc_o | output | 16 | Program counter restored by the last return |
| ret_flags_o | output | 8 | Flags restored by the last return |

## Verification
Counting the request edge as cycle 0, stack transfers occur in cycles 1 to 3 for a short frame and cycles 1 to 4 for a long frame. Done and the updated segment state appear one cycle after the last transfer, so in cycle 4 or cycle 5. Configuration and CSR writes show on the next cycle. The bench changes inputs on falling edges and samples on falling edges. It counts the falling edges from a request to done and compares that count with 4 or 5. A scoreboard queue holds every expected push and pop, and on each falling edge a strobe must match the head of the queue. Any strobe when the queue is empty is a mismatch, so an ignored request is checked by the absence of traffic.

// File: rtl/ifs_pkg.sv
// Shared types of the interrupt stack frame sequencer.
// Assumes a byte-wide stack and a two-byte program counter.
package ifs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PSH_PCL,
        ST_PSH_PCH,
        ST_PSH_FLG,
        ST_PSH_CSR,
        ST_POP_CSR,
        ST_POP_FLG,
        ST_POP_PCH,
        ST_POP_PCL
    } ifs_state_e;
endpackage

// File: rtl/ifs_ctrl.sv
// Sequencer control: accepts entry and return requests, walks the
// push or pop steps one per cycle, latches the frame format at entry
// and holds the in-handler flag. Assumes no nesting: entry is only
// taken outside a handler.
module ifs_ctrl
    import ifs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take_i,
    input  logic       iret_i,
    input  logic       mode_we_i,
    input  logic       mode_wd_i,
    output ifs_state_e state_o,
    output logic       ext_mode_o,
    output logic       frame_ext_o,
    output logic       in_hdl_o,
    output logic       done_o,
    output logic       start_o,
    output logic       entry_end_o,
    output logic       exit_end_o,
    output logic       push_o,
    output logic       pop_o,
    output logic       busy_o
);
    ifs_state_e state_q;
    logic ext_mode_q, frame_ext_q, in_hdl_q, done_q;
    logic ret_go;

    // request qualification and step decode
    always_comb begin
        start_o     = (state_q == ST_IDLE) && take_i && !in_hdl_q;
        ret_go      = (state_q == ST_IDLE) && iret_i && in_hdl_q;
        push_o      = state_q inside {ST_PSH_PCL, ST_PSH_PCH, ST_PSH_FLG, ST_PSH_CSR};
        pop_o       = state_q inside {ST_POP_CSR, ST_POP_FLG, ST_POP_PCH, ST_POP_PCL};
        entry_end_o = ((state_q == ST_PSH_FLG) && !frame_ext_q) || (state_q == ST_PSH_CSR);
        exit_end_o  = (state_q == ST_POP_PCL);
    end

    // format configuration bit
    always_ff @(posedge clk) begin
        if (!rst_n)         ext_mode_q <= 1'b0;
        else if (mode_we_i) ext_mode_q <= mode_wd_i;
    end

    // step sequencing, format latch, handler flag and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            frame_ext_q <= 1'b0;
            in_hdl_q    <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            done_q <= entry_end_o || exit_end_o;
            if (entry_end_o) in_hdl_q <= 1'b1;
            if (exit_end_o)  in_hdl_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_o) begin
                        frame_ext_q <= ext_mode_q;
                        state_q     <= ST_PSH_PCL;
                    end else if (ret_go) begin
                        state_q <= frame_ext_q ? ST_POP_CSR : ST_POP_FLG;
                    end
                end
                ST_PSH_PCL: state_q <= ST_PSH_PCH;
                ST_PSH_PCH: state_q <= ST_PSH_FLG;
                ST_PSH_FLG: state_q <= frame_ext_q ? ST_PSH_CSR : ST_IDLE;
                ST_PSH_CSR: state_q <= ST_IDLE;
                ST_POP_CSR: state_q <= ST_POP_FLG;
                ST_POP_FLG: state_q <= ST_POP_PCH;
                ST_POP_PCH: state_q <= ST_POP_PCL;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o     = state_q;
    assign ext_mode_o  = ext_mode_q;
    assign frame_ext_o = frame_ext_q;
    assign in_hdl_o    = in_hdl_q;
    assign done_o      = done_q;
    assign busy_o      = (state_q != ST_IDLE);

    // transfer counters used only by the frame length checks
    logic [2:0] push_cnt, pop_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_cnt <= '0;
            pop_cnt  <= '0;
        end else begin
            if (start_o)     push_cnt <= '0;
            else if (push_o) push_cnt <= push_cnt + 3'd1;
            if (ret_go)      pop_cnt  <= '0;
            else if (pop_o)  pop_cnt  <= pop_cnt + 3'd1;
        end
    end

    p_mode_rst_r1: assert property (@(posedge clk) !rst_n |=> !ext_mode_q);
    p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        entry_end_o |-> (push_cnt == (frame_ext_q ? 3'd3 : 3'd2)));
    p_pop_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exit_end_o |-> (pop_cnt == (frame_ext_q ? 3'd3 : 3'd2)));
    p_fmt_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hdl_q && $past(in_hdl_q)) |-> $stable(frame_ext_q));
    p_no_reentry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && (in_hdl_q || busy_o)) |=> !(state_q == ST_PSH_PCL));
endmodule

// File: rtl/ifs_frame.sv
// Frame datapath: captures PC and flags at entry, selects the byte
// to push for each step, and collects popped bytes on return.
// Assumes the stack presents its top byte in the cycle of the pop.
module ifs_frame
    import ifs_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SEG_W  = 6,
    localparam int PC_W  = 2 * BYTE_W,
    localparam int PAD_W = BYTE_W - SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ifs_state_e        state_i,
    input  logic              start_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [BYTE_W-1:0] flags_i,
    input  logic [SEG_W-1:0]  csr_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic [BYTE_W-1:0] wdata_o,
    output logic [PC_W-1:0]   ret_pc_o,
    output logic [BYTE_W-1:0] ret_flags_o
);
    logic [PC_W-1:0]   pc_q;
    logic [BYTE_W-1:0] flags_q;

    // snapshot of the context to be stacked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            flags_q <= '0;
        end else if (start_i) begin
            pc_q    <= pc_i;
            flags_q <= flags_i;
        end
    end

    // byte presented on the push port per step
    always_comb begin
        case (state_i)
            ST_PSH_PCL: wdata_o = pc_q[BYTE_W-1:0];
            ST_PSH_PCH: wdata_o = pc_q[PC_W-1:BYTE_W];
            ST_PSH_FLG: wdata_o = flags_q;
            ST_PSH_CSR: wdata_o = {{PAD_W{1'b0}}, csr_i};
            default:    wdata_o = '0;
        endcase
    end

    // collection of the restored context while popping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_pc_o    <= '0;
            ret_flags_o <= '0;
        end else begin
            case (state_i)
                ST_POP_FLG: ret_flags_o              <= rdata_i;
                ST_POP_PCH: ret_pc_o[PC_W-1:BYTE_W]  <= rdata_i;
                ST_POP_PCL: ret_pc_o[BYTE_W-1:0]     <= rdata_i;
                default: ;
            endcase
        end
    end

    p_pcl_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (wdata_o == $past(pc_i[BYTE_W-1:0])));
endmodule

// File: rtl/ifs_seg.sv
// Segment state: the code segment register, the flag that makes the
// interrupt segment stand in for it, and the fetch segment select.
// Assumes CSR writes come only from the core and only matter when idle.
module ifs_seg
    import ifs_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SEG_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ifs_state_e        state_i,
    input  logic              busy_i,
    input  logic              frame_ext_i,
    input  logic              in_hdl_i,
    input  logic              entry_end_i,
    input  logic              exit_end_i,
    input  logic [SEG_W-1:0]  isr_i,
    input  logic              csr_we_i,
    input  logic [SEG_W-1:0]  csr_wd_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic [SEG_W-1:0]  csr_o,
    output logic [SEG_W-1:0]  fetch_seg_o
);
    logic [SEG_W-1:0] csr_q;
    logic             use_isr_q;

    // code segment register: reload at long entry and long return
    always_ff @(posedge clk) begin
        if (!rst_n)                           csr_q <= '0;
        else if (entry_end_i && frame_ext_i)  csr_q <= isr_i;
        else if (state_i == ST_POP_CSR)       csr_q <= rdata_i[SEG_W-1:0];
        else if (csr_we_i && !busy_i)         csr_q <= csr_wd_i;
    end

    // interrupt segment override for the length of a short-format handler
    always_ff @(posedge clk) begin
        if (!rst_n)                           use_isr_q <= 1'b0;
        else if (entry_end_i && !frame_ext_i) use_isr_q <= 1'b1;
        else if (exit_end_i)                  use_isr_q <= 1'b0;
    end

    assign csr_o       = csr_q;
    assign fetch_seg_o = use_isr_q ? isr_i : csr_q;

    p_short_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hdl_i && !frame_ext_i) |-> (fetch_seg_o == isr_i));
    p_long_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_end_i && frame_ext_i) |=> (csr_q == $past(isr_i)));
    p_long_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hdl_i && frame_ext_i) |-> (fetch_seg_o == csr_o));
    p_csr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && (state_i != ST_POP_CSR) && !(entry_end_i && frame_ext_i))
        |=> $stable(csr_q));
endmodule

// File: rtl/intr_frame_seq.sv
// Top of the interrupt stack frame sequencer: wires the control,
// frame datapath and segment state together. Assumes an external
// byte-wide descending stack that shows its top byte combinationally.
module intr_frame_seq
    import ifs_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SEG_W  = 6,
    localparam int PC_W  = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we_i,
    input  logic              mode_wd_i,
    input  logic              irq_take_i,
    input  logic              iret_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [BYTE_W-1:0] flags_i,
    input  logic [SEG_W-1:0]  isr_i,
    input  logic              csr_we_i,
    input  logic [SEG_W-1:0]  csr_wd_i,
    output logic              stk_push_o,
    output logic              stk_pop_o,
    output logic [BYTE_W-1:0] stk_wdata_o,
    input  logic [BYTE_W-1:0] stk_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              ext_mode_o,
    output logic [SEG_W-1:0]  csr_o,
    output logic [SEG_W-1:0]  fetch_seg_o,
    output logic [PC_W-1:0]   ret_pc_o,
    output logic [BYTE_W-1:0] ret_flags_o
);
    ifs_state_e state;
    logic frame_ext, in_hdl, start, entry_end, exit_end;

    ifs_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (irq_take_i),
        .iret_i      (iret_i),
        .mode_we_i   (mode_we_i),
        .mode_wd_i   (mode_wd_i),
        .state_o     (state),
        .ext_mode_o  (ext_mode_o),
        .frame_ext_o (frame_ext),
        .in_hdl_o    (in_hdl),
        .done_o      (done_o),
        .start_o     (start),
        .entry_end_o (entry_end),
        .exit_end_o  (exit_end),
        .push_o      (stk_push_o),
        .pop_o       (stk_pop_o),
        .busy_o      (busy_o)
    );

    ifs_frame #(.BYTE_W(BYTE_W), .SEG_W(SEG_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state),
        .start_i     (start),
        .pc_i        (pc_i),
        .flags_i     (flags_i),
        .csr_i       (csr_o),
        .rdata_i     (stk_rdata_i),
        .wdata_o     (stk_wdata_o),
        .ret_pc_o    (ret_pc_o),
        .ret_flags_o (ret_flags_o)
    );

    ifs_seg #(.BYTE_W(BYTE_W), .SEG_W(SEG_W)) u_seg (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state),
        .busy_i      (busy_o),
        .frame_ext_i (frame_ext),
        .in_hdl_i    (in_hdl),
        .entry_end_i (entry_end),
        .exit_end_i  (exit_end),
        .isr_i       (isr_i),
        .csr_we_i    (csr_we_i),
        .csr_wd_i    (csr_wd_i),
        .rdata_i     (stk_rdata_i),
        .csr_o       (csr_o),
        .fetch_seg_o (fetch_seg_o)
    );

    p_push_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

// File: tb/intr_frame_seq_tb.sv
module intr_frame_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_we, mode_wd, take, iret, csr_we;
    logic [15:0] pc;
    logic [7:0]  flags;
    logic [5:0]  isr, csr_wd;
    logic        push, pop;
    logic [7:0]  wdata, rdata;
    logic        busy, done, ext_mode;
    logic [5:0]  csr, fseg;
    logic [15:0] ret_pc;
    logic [7:0]  ret_flags;

    always #(CLK_PERIOD / 2) clk = ~clk;

    intr_frame_seq u_dut (
        .clk(clk), .rst_n(rst_n), .mode_we_i(mode_we), .mode_wd_i(mode_wd),
        .irq_take_i(take), .iret_i(iret), .pc_i(pc), .flags_i(flags),
        .isr_i(isr), .csr_we_i(csr_we), .csr_wd_i(csr_wd),
        .stk_push_o(push), .stk_pop_o(pop), .stk_wdata_o(wdata),
        .stk_rdata_i(rdata), .busy_o(busy), .done_o(done),
        .ext_mode_o(ext_mode), .csr_o(csr), .fetch_seg_o(fseg),
        .ret_pc_o(ret_pc), .ret_flags_o(ret_flags)
    );

    // descending byte stack model
    logic [7:0] mem [0:31];
    logic [5:0] sp = 6'd32;
    assign rdata = (sp < 6'd32) ? mem[sp[4:0]] : 8'h00;
    always @(posedge clk) begin
        if (push) begin
            mem[sp[4:0] - 5'd1] <= wdata;
            sp <= sp - 6'd1;
        end else if (pop) begin
            sp <= sp + 6'd1;
        end
    end

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct packed { logic is_pop; logic [7:0] data; } item_t;
    item_t exp_q[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // monitor: every stack strobe must match the head of the queue
    always @(negedge clk) begin
        if (rst_n === 1'b1 && (push || pop)) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R8 unexpected stack transfer actual push=%b pop=%b expected none", push, pop);
            end else begin
                item_t it;
                logic [7:0] got;
                it  = exp_q.pop_front();
                got = pop ? rdata : wdata;
                if (it.is_pop !== pop || got !== it.data) begin
                    n_bad++;
                    $display("FAIL R2/R4/R5/R6 stack transfer actual pop=%b data=%h expected pop=%b data=%h",
                             pop, got, it.is_pop, it.data);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic expect_item(input logic is_pop, input logic [7:0] d);
        item_t it;
        it.is_pop = is_pop;
        it.data   = d;
        exp_q.push_back(it);
    endtask

    // raise a one-cycle request and count falling edges until done
    task automatic run_req(input bit is_ret, input bit poke_csr, output int lat, output logic busy1);
        lat = 0;
        busy1 = 1'b0;
        if (is_ret) iret = 1'b1; else take = 1'b1;
        while (lat < 20) begin
            @(negedge clk);
            lat++;
            take = 1'b0;
            iret = 1'b0;
            if (lat == 1) begin
                busy1 = busy;
                if (poke_csr) begin csr_we = 1'b1; csr_wd = 6'h3F; end
            end else begin
                csr_we = 1'b0;
            end
            if (done) break;
        end
    endtask

    task automatic wr_csr(input logic [5:0] v);
        csr_we = 1'b1; csr_wd = v;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic wr_mode(input logic v);
        mode_we = 1'b1; mode_wd = v;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    initial begin
        int lat;
        logic b1;
        rst_n = 1'b0; mode_we = 0; mode_wd = 0; take = 0; iret = 0;
        csr_we = 0; csr_wd = 0; pc = 0; flags = 0; isr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 mode", ext_mode, 0);
        chk("R1 csr", csr, 0);
        chk("R1 fetch", fseg, 0);

        wr_csr(6'h05);
        chk("R9 idle write csr", csr, 6'h05);
        chk("R9 idle write fetch", fseg, 6'h05);

        // short-format entry, CSR write attempted while busy
        pc = 16'h1234; flags = 8'hA5; isr = 6'h2A;
        expect_item(0, 8'h34); expect_item(0, 8'h12); expect_item(0, 8'hA5);
        run_req(0, 1, lat, b1);
        chk("R2 entry latency", lat, 4);
        chk("R2 busy while stacking", b1, 1);
        chk("R2 done pulse", done, 1);
        chk("R3 fetch from isr", fseg, 6'h2A);
        chk("R9 busy write ignored", csr, 6'h05);
        @(negedge clk);
        chk("R2 done one cycle", done, 0);

        // second interrupt inside the handler is ignored
        take = 1'b1;
        @(negedge clk);
        take = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 no reentry busy", busy, 0);
        chk("R8 no reentry fetch", fseg, 6'h2A);

        wr_csr(6'h11);
        chk("R3 csr written", csr, 6'h11);
        chk("R3 fetch unchanged", fseg, 6'h2A);
        isr = 6'h15;
        #1;
        chk("R3 fetch follows isr", fseg, 6'h15);

        wr_mode(1'b1);
        chk("R7 mode now long", ext_mode, 1);

        // short return despite the mode change
        expect_item(1, 8'hA5); expect_item(1, 8'h12); expect_item(1, 8'h34);
        run_req(1, 0, lat, b1);
        chk("R7 short return latency", lat, 4);
        chk("R5 ret pc", ret_pc, 16'h1234);
        chk("R5 ret flags", ret_flags, 8'hA5);
        chk("R5 csr not restored", csr, 6'h11);
        chk("R5 fetch back to csr", fseg, 6'h11);
        chk("R7 frame balanced", exp_q.size(), 0);

        // return outside a handler is ignored
        iret = 1'b1;
        @(negedge clk);
        iret = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 stray return busy", busy, 0);

        // long-format entry
        pc = 16'hBEEF; flags = 8'h3C; isr = 6'h07;
        expect_item(0, 8'hEF); expect_item(0, 8'hBE); expect_item(0, 8'h3C); expect_item(0, 8'h11);
        run_req(0, 0, lat, b1);
        chk("R4 entry latency", lat, 5);
        chk("R4 csr loaded", csr, 6'h07);
        chk("R4 fetch", fseg, 6'h07);
        @(negedge clk);
        wr_csr(6'h30);
        chk("R4 far jump fetch", fseg, 6'h30);

        wr_mode(1'b0);
        expect_item(1, 8'h11); expect_item(1, 8'h3C); expect_item(1, 8'hBE); expect_item(1, 8'hEF);
        run_req(1, 0, lat, b1);
        chk("R6 long return latency", lat, 5);
        chk("R6 csr restored", csr, 6'h11);
        chk("R6 fetch", fseg, 6'h11);
        chk("R6 ret pc", ret_pc, 16'hBEEF);
        chk("R6 ret flags", ret_flags, 8'h3C);
        chk("R7 frame balanced long", exp_q.size(), 0);

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule